// File: doc/BRIEF.md
# Two-Plane Cursor Overlay

This block lays a 64x64 pointer image over the pixel stream of a display controller. Software programs the image location in video memory, the screen position, a hotspot correction, two 24-bit colours, an enable and a freeze bit through a small register port. At the start of each scan line the block decides whether the cursor covers that line. If it does, it reads the 16-byte bitmap row for the line from a synchronous video-memory read port. It then mixes each incoming 32-bit background pixel with the matching cursor bit pair.

Each cursor pixel is coded by a mask bit and a pattern bit. The pixel can show either of two solid colours, leave the screen pixel alone, or invert it. The block takes a line number with a line-start strobe and a per-pixel strobe with the pixel's x coordinate. Frame timing and memory arbitration are done elsewhere.

Top module: `cursor_overlay`

## Requirements
- R1: After reset every register reads zero, the enable and freeze bits are clear, and pixels pass through unchanged.
- R2: Register map (reg_addr): 0 = image offset, 1 = position, 2 = hotspot, 3 = colour 0, 4 = colour 1, 5 = control (bit 0 enable). Addresses 6 and 7 read zero. The masks applied on write are:
  - image offset: 0x07FFFFF0
  - position: 0x3FFF0FFF, with x in bits 29:16 and y in bits 11:0
  - hotspot: 0x003F003F, with x in bits 21:16 and y in bits 5:0
  - colours: 0x00FFFFFF
  Reads of the offset, position and hotspot registers return the freeze bit in bit 31.
- R3: Writing the offset, position or hotspot register sets the freeze bit to bit 31 of the written word. While the freeze bit is set, the offset, position, hotspot and colours used for drawing keep their values and new writes are only stored. Clearing the bit applies the stored values at once.
- R4: The row fetch address is (display base AND 0x07FFFFFF) + image offset − hotspot x − 16 × hotspot y + 16 × (line − cursor y), computed modulo 2^32. A row is read as consecutive words of MEM_W bits at that address plus 0, MEM_W/8, and so on. The first byte of each word sits in the word's low byte.
- R5: A row is fetched only when the line start sees the enable set and the line lies in cursor y to cursor y + 63 and the line is no greater than vdisp_end.
- R6: For a drawn pixel, mask=1 with pattern=1 outputs the bitwise complement of the background. Mask=1 with pattern=0 outputs the background. Mask=0 outputs {colour1, 8'hFF} when pattern=1 and {colour0, 8'hFF} when pattern=0.
- R7: Pixel x = cursor x + k (k from 0 to 63) uses byte k/8 of the row for the mask and byte 8 + k/8 for the pattern, at bit 7 − (k mod 8). Pixels outside that span pass through unchanged.
- R8: Pixels with x ≥ (hdisp_field + 1) × 8 pass through unchanged.
- R9: out_valid follows pix_valid one cycle later, and out_pixel belongs to the pixel presented in that earlier cycle.
- R10: The row is usable from the (MEM_W-word count + 2)th cycle after the line-start cycle. Pixels presented earlier on that line pass through unchanged.
- R11: With enable clear, no row is fetched and every pixel passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| disp_base | input | 32 | Display memory base; low 27 bits used |
| hdisp_field | input | 11 | Horizontal display field; width is (field+1)*8 |
| vdisp_end | input | 12 | Last visible line |
| line_start | input | 1 | Start-of-line strobe |
| line_num | input | 12 | Line number, valid with line_start |
| pix_valid | input | 1 | Background pixel strobe |
| pix_x | input | 14 | X coordinate of the background pixel |
| bg_pixel | input | 32 | Background pixel |
| out_valid | output | 1 | Output pixel strobe |
| out_pixel | output | 32 | Mixed pixel |
| mem_rd_en | output | 1 | Video memory read request |
| mem_addr | output | 32 | Video memory byte address |
| mem_rdata | input | MEM_W | Read data, one cycle after the request |

## Verification
The bench keeps a model that sweeps the cursor span of each line from before its left edge to past its right edge. The video-memory bytes derived from each address produce all four mask/pattern codes within one row, so a swapped plane, a mirrored bit order or a wrong colour gives a distinct error. Lines just above, just inside, and just below the 64-line window, and one past the vertical end, separate the window compare from the fetch. A cursor placed across the right edge isolates the clip. A nonzero hotspot and an unaligned base show an address term with the wrong sign or scale. Pixels sent right after a line start, a freeze with new position and colour writes, and a disabled cursor each show a distinct pass-through case.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int CUR_DIM   = 64;
  localparam int ROW_BYTES = 16;
  localparam int ROW_BITS  = ROW_BYTES * 8;
  localparam int PLANE_BITS = ROW_BITS / 2;

  localparam logic [31:0] OFF_MASK = 32'h07FF_FFF0;
  localparam logic [31:0] POS_MASK = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_MASK = 32'h003F_003F;
  localparam logic [31:0] COL_MASK = 32'h00FF_FFFF;
  localparam logic [31:0] BASE_MASK = 32'h07FF_FFFF;

  typedef enum logic [2:0] {
    CSR_OFFSET = 3'd0,
    CSR_POS    = 3'd1,
    CSR_HOT    = 3'd2,
    CSR_COL0   = 3'd3,
    CSR_COL1   = 3'd4,
    CSR_CTRL   = 3'd5
  } csr_sel_e;

  // Byte address of the bitmap row for a given cursor row.
  function automatic logic [31:0] row_fetch_addr(
    input logic [31:0] base,
    input logic [31:0] img_off,
    input logic [5:0]  hot_x,
    input logic [5:0]  hot_y,
    input logic [5:0]  row
  );
    logic [31:0] a;
    a = (base & BASE_MASK) + img_off;
    a = a - {26'd0, hot_x} - {22'd0, hot_y, 4'd0};
    a = a + {22'd0, row, 4'd0};
    return a;
  endfunction

  function automatic logic [14:0] visible_width(input logic [10:0] field);
    return ({4'd0, field} + 15'd1) << 3;
  endfunction

  // Mask/pattern pair applied to one background pixel.
  function automatic logic [31:0] blend_pixel(
    input logic        mask_b,
    input logic        patt_b,
    input logic [31:0] bg,
    input logic [23:0] col0,
    input logic [23:0] col1
  );
    logic [31:0] r;
    if (mask_b) r = patt_b ? ~bg : bg;
    else        r = {(patt_b ? col1 : col0), 8'hFF};
    return r;
  endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        enable,
  output logic        frozen,
  output logic [31:0] act_off,
  output logic [13:0] act_x,
  output logic [11:0] act_y,
  output logic [5:0]  act_hx,
  output logic [5:0]  act_hy,
  output logic [23:0] act_c0,
  output logic [23:0] act_c1
);

  logic [31:0] off_q, pos_q, hot_q, c0_q, c1_q;
  logic [31:0] off_n, pos_n, hot_n, c0_n, c1_n;
  logic        en_q, en_n, lock_q, lock_n;

  always_comb begin
    off_n = off_q; pos_n = pos_q; hot_n = hot_q;
    c0_n = c0_q; c1_n = c1_q; en_n = en_q; lock_n = lock_q;
    if (we) begin
      case (addr)
        CSR_OFFSET: begin off_n = wdata & OFF_MASK; lock_n = wdata[31]; end
        CSR_POS:    begin pos_n = wdata & POS_MASK; lock_n = wdata[31]; end
        CSR_HOT:    begin hot_n = wdata & HOT_MASK; lock_n = wdata[31]; end
        CSR_COL0:   c0_n = wdata & COL_MASK;
        CSR_COL1:   c1_n = wdata & COL_MASK;
        CSR_CTRL:   en_n = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0; pos_q <= '0; hot_q <= '0; c0_q <= '0; c1_q <= '0;
      en_q <= 1'b0; lock_q <= 1'b0;
      act_off <= '0; act_x <= '0; act_y <= '0; act_hx <= '0; act_hy <= '0;
      act_c0 <= '0; act_c1 <= '0;
    end else begin
      off_q <= off_n; pos_q <= pos_n; hot_q <= hot_n;
      c0_q <= c0_n; c1_q <= c1_n; en_q <= en_n; lock_q <= lock_n;
      if (!lock_n) begin
        act_off <= off_n;
        act_x   <= pos_n[29:16];
        act_y   <= pos_n[11:0];
        act_hx  <= hot_n[21:16];
        act_hy  <= hot_n[5:0];
        act_c0  <= c0_n[23:0];
        act_c1  <= c1_n[23:0];
      end
    end
  end

  always_comb begin
    case (addr)
      CSR_OFFSET: rdata = off_q | {lock_q, 31'd0};
      CSR_POS:    rdata = pos_q | {lock_q, 31'd0};
      CSR_HOT:    rdata = hot_q | {lock_q, 31'd0};
      CSR_COL0:   rdata = c0_q;
      CSR_COL1:   rdata = c1_q;
      CSR_CTRL:   rdata = {31'd0, en_q};
      default:    rdata = '0;
    endcase
  end

  assign enable = en_q;
  assign frozen = lock_q;

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> ($stable(act_x) && $stable(act_y) && $stable(act_c0) && $stable(act_c1) && $stable(act_off))) // R3
    else $error("frozen cursor state changed");

  AST_RELEASE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> (act_x == pos_q[29:16] && act_y == pos_q[11:0])) // R3
    else $error("release did not apply stored position");

endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch
  import cursor_pkg::*;
#(
  parameter int MEM_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic [11:0]         line_num,
  input  logic                enable,
  input  logic [11:0]         cur_y,
  input  logic [11:0]         vdisp_end,
  input  logic [31:0]         disp_base,
  input  logic [31:0]         img_off,
  input  logic [5:0]          hot_x,
  input  logic [5:0]          hot_y,
  output logic                mem_rd_en,
  output logic [31:0]         mem_addr,
  input  logic [MEM_W-1:0]    mem_rdata,
  output logic [ROW_BITS-1:0] row_bits,
  output logic                line_ready
);

  localparam int BEATS      = ROW_BITS / MEM_W;
  localparam int BEAT_BYTES = MEM_W / 8;
  localparam int CNT_W      = $clog2(BEATS) + 1;

  logic             busy_q, pend_q, ready_q;
  logic [CNT_W-1:0] issue_q, cap_q;
  logic [31:0]      addr_q;
  logic             in_window;
  logic [5:0]       row_idx;

  assign in_window = enable && (line_num >= cur_y)
                  && ({1'b0, line_num} <= ({1'b0, cur_y} + 13'd63))
                  && (line_num <= vdisp_end);
  assign row_idx   = line_num[5:0] - cur_y[5:0];

  assign mem_rd_en  = busy_q;
  assign mem_addr   = addr_q + (32'(issue_q) * BEAT_BYTES);
  assign line_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; pend_q <= 1'b0; ready_q <= 1'b0;
      issue_q <= '0; cap_q <= '0; addr_q <= '0;
    end else if (line_start) begin
      busy_q  <= in_window;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
      issue_q <= '0;
      cap_q   <= '0;
      if (in_window) addr_q <= row_fetch_addr(disp_base, img_off, hot_x, hot_y, row_idx);
    end else begin
      pend_q <= busy_q;
      if (busy_q) begin
        issue_q <= issue_q + 1'b1;
        if (issue_q == CNT_W'(BEATS - 1)) busy_q <= 1'b0;
      end
      if (pend_q) begin
        cap_q <= cap_q + 1'b1;
        if (cap_q == CNT_W'(BEATS - 1)) ready_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    logic [MEM_W-1:0] beat_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beat_r <= '0;
      else if (!line_start && pend_q && cap_q == CNT_W'(g)) beat_r <= mem_rdata;
    end
    assign row_bits[g*MEM_W +: MEM_W] = beat_r;
  end

  AST_NO_FETCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !enable) |=> !mem_rd_en) // R11
    else $error("fetch while disabled");

  AST_NO_FETCH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && line_num < cur_y) |=> !mem_rd_en) // R5
    else $error("fetch above cursor window");

  AST_READY_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !line_ready) // R10
    else $error("row marked ready during fetch");

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en) && !$past(line_start)) |-> (mem_addr == $past(mem_addr) + BEAT_BYTES)) // R4
    else $error("fetch address step wrong");

endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_valid,
  input  logic [13:0]         pix_x,
  input  logic [31:0]         bg_pixel,
  input  logic                enable,
  input  logic                line_ready,
  input  logic [13:0]         cur_x,
  input  logic [10:0]         hdisp_field,
  input  logic [ROW_BITS-1:0] row_bits,
  input  logic [23:0]         col0,
  input  logic [23:0]         col1,
  output logic                out_valid,
  output logic [31:0]         out_pixel
);

  logic       in_span, beyond_edge, draw;
  logic [5:0] idx;
  logic [6:0] mask_pos, patt_pos;
  logic       mask_b, patt_b;

  assign in_span     = (pix_x >= cur_x) && ({1'b0, pix_x} < ({1'b0, cur_x} + 15'd64));
  assign beyond_edge = ({1'b0, pix_x} >= visible_width(hdisp_field));
  assign draw        = enable && line_ready && in_span && !beyond_edge;

  assign idx      = pix_x[5:0] - cur_x[5:0];
  assign mask_pos = {1'b0, idx[5:3], 3'd7 - idx[2:0]};
  assign patt_pos = 7'(PLANE_BITS) + mask_pos;
  assign mask_b   = row_bits[mask_pos];
  assign patt_b   = row_bits[patt_pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid)
        out_pixel <= draw ? blend_pixel(mask_b, patt_b, bg_pixel, col0, col1) : bg_pixel;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(pix_valid)) // R9
    else $error("output strobe latency wrong");

  AST_CLIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && beyond_edge) |=> (out_pixel == $past(bg_pixel))) // R8
    else $error("clipped pixel altered");

  AST_NOT_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_ready) |=> (out_pixel == $past(bg_pixel))) // R10
    else $error("pixel altered before row ready");

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MEM_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      disp_base,
  input  logic [10:0]      hdisp_field,
  input  logic [11:0]      vdisp_end,
  input  logic             line_start,
  input  logic [11:0]      line_num,
  input  logic             pix_valid,
  input  logic [13:0]      pix_x,
  input  logic [31:0]      bg_pixel,
  output logic             out_valid,
  output logic [31:0]      out_pixel,
  output logic             mem_rd_en,
  output logic [31:0]      mem_addr,
  input  logic [MEM_W-1:0] mem_rdata
);

  logic                enable, frozen, line_ready;
  logic [31:0]         act_off;
  logic [13:0]         act_x;
  logic [11:0]         act_y;
  logic [5:0]          act_hx, act_hy;
  logic [23:0]         act_c0, act_c1;
  logic [ROW_BITS-1:0] row_bits;

  cursor_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .enable(enable), .frozen(frozen), .act_off(act_off),
    .act_x(act_x), .act_y(act_y), .act_hx(act_hx), .act_hy(act_hy),
    .act_c0(act_c0), .act_c1(act_c1)
  );

  cursor_fetch #(.MEM_W(MEM_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .enable(enable), .cur_y(act_y), .vdisp_end(vdisp_end), .disp_base(disp_base),
    .img_off(act_off), .hot_x(act_hx), .hot_y(act_hy), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .row_bits(row_bits),
    .line_ready(line_ready)
  );

  cursor_mixer u_mix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
    .bg_pixel(bg_pixel), .enable(enable), .line_ready(line_ready), .cur_x(act_x),
    .hdisp_field(hdisp_field), .row_bits(row_bits), .col0(act_c0), .col1(act_c1),
    .out_valid(out_valid), .out_pixel(out_pixel)
  );

  AST_FROZEN_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> $stable(act_x)) // R3
    else $error("cursor moved while frozen");

endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_W = 64;
  localparam int BEATS = 128 / MEM_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] disp_base = '0;
  logic [10:0] hdisp_field = '0;
  logic [11:0] vdisp_end = '0;
  logic        line_start = 1'b0;
  logic [11:0] line_num = '0;
  logic        pix_valid = 1'b0;
  logic [13:0] pix_x = '0;
  logic [31:0] bg_pixel = '0;
  logic        out_valid;
  logic [31:0] out_pixel;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [MEM_W-1:0] mem_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  cursor_overlay #(.MEM_W(MEM_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'((a * 29) ^ (a >> 5) ^ 32'h5A);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en)
      for (int k = 0; k < MEM_W/8; k++) mem_rdata[8*k +: 8] <= mbyte(mem_addr + 32'(k));
  end

  // ---------------- reference model ----------------
  logic [31:0] p_off, p_pos, p_hot, p_c0, p_c1;
  bit p_en, p_lock;
  int a_x, a_y, a_hx, a_hy;
  logic [31:0] a_off, a_c0, a_c1;
  bit m_hit;
  longint cyc = 0, ready_at = 0;
  logic [7:0] rb [16];
  logic [31:0] exp_addr;
  int beats_left = 0, beat_no = 0;
  bit exp_v = 0;
  logic [31:0] exp_p;
  string exp_tag;
  string phase = "R6";

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return p_off | {p_lock, 31'd0};
      1: return p_pos | {p_lock, 31'd0};
      2: return p_hot | {p_lock, 31'd0};
      3: return p_c0;
      4: return p_c1;
      5: return {31'd0, p_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic fail_line(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      p_off = 0; p_pos = 0; p_hot = 0; p_c0 = 0; p_c1 = 0; p_en = 0; p_lock = 0;
      a_x = 0; a_y = 0; a_hx = 0; a_hy = 0; a_off = 0; a_c0 = 0; a_c1 = 0;
      m_hit = 0; exp_v = 0; beats_left = 0;
    end else begin
      exp_v = pix_valid;
      if (pix_valid) begin
        int k;
        int w;
        k = int'(pix_x) - a_x;
        w = (int'(hdisp_field) + 1) * 8;
        exp_p = bg_pixel;
        if (!p_en) exp_tag = "R11";
        else if (!(m_hit && cyc >= ready_at)) exp_tag = "R10";
        else if (int'(pix_x) >= w) exp_tag = "R8";
        else if (k < 0 || k > 63) exp_tag = "R7";
        else begin
          bit mb, pb;
          mb = rb[k/8][7 - (k % 8)];
          pb = rb[8 + k/8][7 - (k % 8)];
          exp_tag = (phase == "R6") ? "R6/R7" : phase;
          if (mb && pb) exp_p = ~bg_pixel;
          else if (!mb) exp_p = {(pb ? a_c1[23:0] : a_c0[23:0]), 8'hFF};
        end
      end
      if (mem_rd_en) begin
        checks++;
        if (beats_left == 0) fail_line("R5", "unexpected read", mem_addr, 32'd0);
        else begin
          if (mem_addr !== exp_addr + 32'(beat_no * (MEM_W/8)))
            fail_line("R4", "fetch address", mem_addr, exp_addr + 32'(beat_no * (MEM_W/8)));
          beats_left--; beat_no++;
        end
      end
      if (line_start) begin
        int ln;
        ln = int'(line_num);
        m_hit = p_en && ln >= a_y && ln <= a_y + 63 && ln <= int'(vdisp_end);
        beats_left = m_hit ? BEATS : 0;
        beat_no = 0;
        if (m_hit) begin
          exp_addr = (disp_base % 32'h0800_0000) + a_off - 32'(a_hx) - 32'(16 * a_hy) + 32'(16 * (ln - a_y));
          for (int b = 0; b < 16; b++) rb[b] = mbyte(exp_addr + 32'(b));
          ready_at = cyc + BEATS + 2;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          0: begin p_off = reg_wdata & 32'h07FF_FFF0; p_lock = reg_wdata[31]; end
          1: begin p_pos = reg_wdata & 32'h3FFF_0FFF; p_lock = reg_wdata[31]; end
          2: begin p_hot = reg_wdata & 32'h003F_003F; p_lock = reg_wdata[31]; end
          3: p_c0 = reg_wdata & 32'h00FF_FFFF;
          4: p_c1 = reg_wdata & 32'h00FF_FFFF;
          5: p_en = reg_wdata[0];
          default: ;
        endcase
      end
      if (!p_lock) begin
        a_off = p_off; a_x = int'(p_pos[29:16]); a_y = int'(p_pos[11:0]);
        a_hx = int'(p_hot[21:16]); a_hy = int'(p_hot[5:0]); a_c0 = p_c0; a_c1 = p_c1;
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid !== exp_v) begin
        checks++;
        fail_line("R9", "out_valid", {31'd0, out_valid}, {31'd0, exp_v});
      end else if (exp_v) begin
        checks++;
        if (out_pixel !== exp_p) fail_line(exp_tag, "pixel", out_pixel, exp_p);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_check(input int a, input string tag);
    @(negedge clk); reg_addr = 3'(a); #1;
    checks++;
    if (reg_rdata !== exp_read(a)) fail_line(tag, "register read", reg_rdata, exp_read(a));
  endtask

  task automatic do_line(input int ln, input int x0, input int n, input bit early);
    @(negedge clk); line_start = 1; line_num = 12'(ln);
    @(negedge clk); line_start = 0;
    if (early) begin
      for (int i = 0; i < 2; i++) begin
        pix_valid = 1; pix_x = 14'(x0 + 5 + i); bg_pixel = 32'hA5A5_0000 + 32'(i);
        @(negedge clk);
      end
      pix_valid = 0;
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1; pix_x = 14'(x0 + i);
      bg_pixel = {8'(ln), 8'(x0 + i), 16'(i * 977 + 3)};
      @(negedge clk);
    end
    pix_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_check(a, "R1");
    do_line(10, 0, 4, 0);  // R1 pass-through with everything clear

    // R2 masks and freeze readback
    wr(1, 32'hFFFF_FFFF); rd_check(1, "R2"); rd_check(0, "R2");
    wr(2, 32'hFFFF_FFFF); rd_check(2, "R2");
    wr(0, 32'hFFFF_FFFF); rd_check(0, "R2");
    wr(3, 32'hFFFF_FFFF); rd_check(3, "R2");
    wr(4, 32'hFF12_3456); rd_check(4, "R2");
    wr(5, 32'hFFFF_FFFF); rd_check(5, "R2");
    rd_check(6, "R2"); rd_check(7, "R2");
    wr(5, 32'h0);

    // main setup
    disp_base = 32'hF800_0123; hdisp_field = 11'd79; vdisp_end = 12'd479;
    wr(0, 32'h0000_0200);
    wr(2, 32'h0002_0003);           // hotspot x=2, y=3
    wr(3, 32'h0011_2233);
    wr(4, 32'h00CC_DDEE);
    wr(1, 32'h0064_0032);           // x=100, y=50
    wr(5, 32'h1);
    rd_check(1, "R3");
    // R5/R6/R7 window edges
    do_line(49, 90, 84, 0);
    do_line(50, 90, 84, 0);
    do_line(77, 90, 84, 0);
    do_line(113, 90, 84, 0);
    do_line(114, 90, 84, 0);
    // R10 early pixels
    do_line(60, 100, 8, 1);
    // R8 clip at the right edge
    wr(1, 32'h0258_0064);           // x=600, y=100
    do_line(120, 590, 74, 0);
    // R5 vertical end
    vdisp_end = 12'd125;
    do_line(126, 600, 40, 0);
    do_line(125, 600, 40, 0);
    vdisp_end = 12'd479;
    // R3 freeze
    phase = "R3";
    wr(1, 32'h8190_0064);           // freeze, new x=400
    wr(3, 32'h00AB_CDEF);
    wr(0, 32'h8000_4000);
    rd_check(0, "R3"); rd_check(1, "R3");
    do_line(101, 590, 74, 0);
    wr(2, 32'h0001_0001);           // release with new hotspot
    rd_check(2, "R3");
    do_line(102, 390, 84, 0);
    // R11 disabled
    phase = "R6";
    wr(5, 32'h0);
    do_line(103, 390, 84, 0);
    wr(5, 32'h1);
    do_line(104, 390, 84, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule